// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates eight interrupt request lines. Each line is captured into a pending register, either by following its input level or by latching a rising edge. Pending lines that are not masked compete on a rotating priority scale: a line's rank is its number minus a 3-bit rotation base, taken modulo 8, and rank 0 is the strongest. The strongest candidate raises the interrupt output only if it strictly outranks every line already in service.

The in-service register is set by an acknowledge pulse. The pulse marks the current winner in service and consumes its request if the line is edge triggered. An end-of-service pulse naming a line clears that line's in-service bit. Two exclusions apply to the in-service comparison. With special masking on, masked lines are left out of the in-service set. With nested cascading on in a master, in-service line 2 (the cascade input) is ignored.

The output is a two-state machine. ST_QUIET means no interrupt. ST_RAISE means the interrupt output is high and the winning line is reported. On every clock it moves to ST_RAISE when the resolver finds a winner and to ST_QUIET when it does not. The mask, rotation base and mode flags are registered each cycle, and all state resets to zero.

Top module: `prio_irq_resolver`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the interrupt output is 0 and the winning line output is 0. Reset empties the pending, in-service and last-level registers, the mask register and the rotation base.
- R2: Among unmasked pending lines, the one with the smallest (line − base) mod 8 wins. Its line number (0..7) appears on win_line_o while irq_o is 1. win_line_o is 0 while irq_o is 0.
- R3: A line whose mask bit is 1 never wins. If all pending lines are masked, irq_o is 0.
- R4: A winner exists only if its rank is strictly smaller than the best rank in the effective in-service set. An in-service line of equal or better rank holds irq_o at 0.
- R5: With special_mask_i = 1, in-service bits whose mask bit is 1 are left out of the comparison in R4.
- R6: With nest_i = 1 and master_i = 1, in-service bit 2 is left out of the comparison in R4. With master_i = 0 it counts.
- R7: A line with lvl_i bit = 1 is pending exactly while its input is high. It stops being pending once the input goes low.
- R8: A line with lvl_i bit = 0 becomes pending on a 0-to-1 change of its input. It stays pending after the input falls. Holding the input high does not make it pending again.
- R9: An ack_i pulse while a winner exists sets that line's in-service bit. It clears the line's pending bit only if the line is edge triggered.
- R10: An eoi_i pulse clears the in-service bit of line eoi_line_i.
- R11: A change on the request inputs reaches irq_o after two rising clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Raw interrupt request lines |
| lvl_i | input | 8 | Trigger mode per line: 1 = level, 0 = edge |
| mask_i | input | 8 | Mask per line, 1 = masked |
| base_i | input | 3 | Rotation base (line that gets rank 0) |
| special_mask_i | input | 1 | Special mask mode |
| nest_i | input | 1 | Special nested cascade mode |
| master_i | input | 1 | Block sits in the master position |
| ack_i | input | 1 | Acknowledge the current winner |
| eoi_i | input | 1 | End service of line eoi_line_i |
| eoi_line_i | input | 3 | Line whose in-service bit is cleared |
| irq_o | output | 1 | Interrupt output |
| win_line_o | output | 3 | Winning line number |

## Verification
A table of level-triggered request, mask and rotation-base combinations with nothing in service isolates the ranking arithmetic. It shows that the winner wraps correctly across the base and that masking redirects it. Directed sequences then fill the in-service register through acknowledges. They compare equal-rank and better-rank requests, and toggle special masking and nested cascading in master and non-master positions. Edge-mode pulses, held levels and re-raised inputs separate latching on a rise from following the level. A mid-run reset shows that the in-service state is lost.

// File: rtl/prio_pkg.sv
package prio_pkg;
    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_RAISE = 1'b1
    } out_state_t;
endpackage

// File: rtl/prio_rank_find.sv
module prio_rank_find #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  set_i,
    input  logic [LW-1:0] base_i,
    output logic [LW:0]   rank_o
);
    // Scan from weakest rank to strongest so the strongest hit is kept.
    always_comb begin
        rank_o = (LW+1)'(N);
        for (int r = N - 1; r >= 0; r--) begin
            logic [LW-1:0] idx;
            idx = LW'(r) + base_i;
            if (set_i[idx]) rank_o = (LW+1)'(r);
        end
    end
endmodule

// File: rtl/prio_req_capture.sv
module prio_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] irr_o
);
    logic [N-1:0] last_q;
    logic [N-1:0] rise;
    logic [N-1:0] irr_next;

    assign rise = req_i & ~last_q;

    // Level lines copy the input; edge lines latch a rise and hold until consumed.
    always_comb begin
        irr_next = (lvl_i & req_i) | (~lvl_i & ((irr_o & ~clr_i) | rise));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_o  <= '0;
            last_q <= '0;
        end else begin
            irr_o  <= irr_next;
            last_q <= req_i;
        end
    end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
    import prio_pkg::*;
#(
    parameter int N            = 8,
    parameter int CASCADE_LINE = 2,
    parameter int LW           = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  lvl_i,
    input  logic [N-1:0]  mask_i,
    input  logic [LW-1:0] base_i,
    input  logic          special_mask_i,
    input  logic          nest_i,
    input  logic          master_i,
    input  logic          ack_i,
    input  logic          eoi_i,
    input  logic [LW-1:0] eoi_line_i,
    output logic          irq_o,
    output logic [LW-1:0] win_line_o
);
    logic [N-1:0]  mask_q;
    logic [LW-1:0] base_q;
    logic          smm_q, nest_q, mst_q;
    logic [N-1:0]  isr_q;
    logic [N-1:0]  irr_q;

    logic [N-1:0]  cand;
    logic [N-1:0]  svc;
    logic [LW:0]   cand_rank;
    logic [LW:0]   svc_rank;
    logic          hit;
    logic [LW-1:0] hit_line;
    logic [N-1:0]  ack_set;
    logic [N-1:0]  edge_clr;
    logic [N-1:0]  eoi_clr;

    out_state_t    st_q, st_next;
    logic [LW-1:0] win_q, win_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            base_q <= '0;
            smm_q  <= 1'b0;
            nest_q <= 1'b0;
            mst_q  <= 1'b0;
        end else begin
            mask_q <= mask_i;
            base_q <= base_i;
            smm_q  <= special_mask_i;
            nest_q <= nest_i;
            mst_q  <= master_i;
        end
    end

    prio_req_capture #(.N(N)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .lvl_i (lvl_i),
        .clr_i (edge_clr),
        .irr_o (irr_q)
    );

    // Effective candidate and in-service sets.
    always_comb begin
        cand = irr_q & ~mask_q;
        svc  = isr_q;
        if (smm_q) svc = svc & ~mask_q;
        if (nest_q && mst_q) svc[CASCADE_LINE] = 1'b0;
    end

    prio_rank_find #(.N(N)) u_cand_find (
        .set_i  (cand),
        .base_i (base_q),
        .rank_o (cand_rank)
    );

    prio_rank_find #(.N(N)) u_svc_find (
        .set_i  (svc),
        .base_i (base_q),
        .rank_o (svc_rank)
    );

    assign hit      = cand_rank < svc_rank;
    assign hit_line = cand_rank[LW-1:0] + base_q;

    always_comb begin
        ack_set = '0;
        eoi_clr = '0;
        if (ack_i && hit) ack_set[hit_line] = 1'b1;
        if (eoi_i) eoi_clr[eoi_line_i] = 1'b1;
        edge_clr = ack_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~eoi_clr) | ack_set;
    end

    // Output state machine.
    always_comb begin
        st_next  = st_q;
        win_next = '0;
        unique case (st_q)
            ST_QUIET: if (hit) st_next = ST_RAISE;
            ST_RAISE: if (!hit) st_next = ST_QUIET;
            default:  st_next = ST_QUIET;
        endcase
        if (hit) win_next = hit_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_QUIET;
            win_q <= '0;
        end else begin
            st_q  <= st_next;
            win_q <= win_next;
        end
    end

    always_comb begin
        irq_o      = (st_q == ST_RAISE);
        win_line_o = win_q;
    end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req_i,
    input logic [N-1:0]  lvl_i,
    input logic          ack_i,
    input logic          eoi_i,
    input logic [LW-1:0] eoi_line_i,
    input logic          irq_o,
    input logic [LW-1:0] win_line_o,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  irr_q,
    input logic [N-1:0]  isr_q,
    input logic          hit,
    input logic [LW-1:0] hit_line
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && win_line_o == '0));

    // R3
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((($past(mask_q) >> win_line_o) & N'(1)) == '0));

    // R2
    a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((($past(irr_q) >> win_line_o) & N'(1)) != '0));

    // R9
    a_r9_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && hit) |=> (((isr_q >> $past(hit_line)) & N'(1)) != '0));

    // R10
    a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(ack_i && hit && hit_line == eoi_line_i))
        |=> (((isr_q >> $past(eoi_line_i)) & N'(1)) == '0));

    // R7
    a_r7_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((irr_q ^ $past(req_i)) & $past(lvl_i)) == '0));

    // R8
    a_r8_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ack_i) |=> (($past(irr_q) & ~$past(lvl_i) & ~irr_q) == '0));
endmodule

bind prio_irq_resolver prio_resolver_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .lvl_i      (lvl_i),
    .ack_i      (ack_i),
    .eoi_i      (eoi_i),
    .eoi_line_i (eoi_line_i),
    .irq_o      (irq_o),
    .win_line_o (win_line_o),
    .mask_q     (mask_q),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .hit        (hit),
    .hit_line   (hit_line)
);

// File: tb/prio_irq_resolver_bench.sv
module prio_irq_resolver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, lvl = '0, mask = '0;
    logic [2:0] base = '0, eoi_line = '0;
    logic       smm = 1'b0, nest = 1'b0, mst = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic       irq;
    logic [2:0] win;
    int         total = 0, bad = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    prio_irq_resolver u_prio_irq_resolver (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_i(lvl), .mask_i(mask),
        .base_i(base), .special_mask_i(smm), .nest_i(nest), .master_i(mst),
        .ack_i(ack), .eoi_i(eoi), .eoi_line_i(eoi_line),
        .irq_o(irq), .win_line_o(win)
    );

    // Fields: req[22:15] mask[14:7] base[6:4] irq[3] line[2:0]
    localparam logic [22:0] VEC [10] = '{
        {8'h00, 8'h00, 3'd0, 1'b0, 3'd0},
        {8'h28, 8'h00, 3'd0, 1'b1, 3'd3},
        {8'h28, 8'h00, 3'd4, 1'b1, 3'd5},
        {8'h81, 8'h00, 3'd1, 1'b1, 3'd7},
        {8'h81, 8'h00, 3'd0, 1'b1, 3'd0},
        {8'h28, 8'h08, 3'd0, 1'b1, 3'd5},
        {8'hFF, 8'hFF, 3'd0, 1'b0, 3'd0},
        {8'hFF, 8'h7F, 3'd3, 1'b1, 3'd7},
        {8'h06, 8'h00, 3'd2, 1'b1, 3'd2},
        {8'h06, 8'h00, 3'd3, 1'b1, 3'd1}
    };

    task automatic chk(input string rid, input logic ei, input logic [2:0] el);
        total++;
        if (irq !== ei || (ei && win !== el) || (!ei && win !== 3'd0)) begin
            bad++;
            $display("FAIL %s: irq=%0b line=%0d expected irq=%0b line=%0d",
                     rid, irq, win, ei, ei ? el : 3'd0);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        settle();
    endtask

    task automatic pulse_eoi(input logic [2:0] l);
        @(negedge clk); eoi = 1'b1; eoi_line = l;
        @(negedge clk); eoi = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 1'b0, 3'd0);

        // Ranking table: level lines, nothing in service.
        lvl = 8'hFF;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            req  = VEC[i][22:15];
            mask = VEC[i][14:7];
            base = VEC[i][6:4];
            settle();
            chk(VEC[i][14:7] != 0 ? "R3" : "R2", VEC[i][3], VEC[i][2:0]);
        end

        // In-service comparison with a level line (R4, R9, R10).
        req = 8'h10; mask = 0; base = 0; settle();
        chk("R2", 1'b1, 3'd4);
        pulse_ack();
        chk("R4", 1'b0, 3'd0);          // equal rank in service
        pulse_eoi(3'd4);
        chk("R10", 1'b1, 3'd4);         // level request survived ack (R9)
        pulse_ack();
        req = 8'h30; settle();
        chk("R4", 1'b0, 3'd0);          // line 5 is worse than line 4
        req = 8'h12; settle();
        chk("R4", 1'b1, 3'd1);          // line 1 strictly better

        // Special mask (R5): isr[4] set, request line 5.
        req = 8'h20; mask = 8'h10; settle();
        chk("R5", 1'b0, 3'd0);
        smm = 1'b1; settle();
        chk("R5", 1'b1, 3'd5);
        smm = 1'b0; mask = 0;
        pulse_eoi(3'd4);

        // Nested cascade (R6).
        req = 8'h04; settle();
        pulse_ack();
        chk("R6", 1'b0, 3'd0);
        nest = 1'b1; mst = 1'b1; settle();
        chk("R6", 1'b1, 3'd2);
        mst = 1'b0; settle();
        chk("R6", 1'b0, 3'd0);
        nest = 1'b0;
        pulse_eoi(3'd2);

        // Level follows input (R7).
        req = 8'h01; settle();
        chk("R7", 1'b1, 3'd0);
        req = 8'h00; settle();
        chk("R7", 1'b0, 3'd0);

        // Edge lines (R8, R9, R11).
        lvl = 8'h00; settle();
        @(negedge clk); req = 8'h08;
        @(negedge clk);
        chk("R11", 1'b0, 3'd0);
        @(negedge clk);
        chk("R11", 1'b1, 3'd3);
        req = 8'h00; settle();
        chk("R8", 1'b1, 3'd3);          // held after input falls
        pulse_ack();
        chk("R9", 1'b0, 3'd0);
        pulse_eoi(3'd3);
        chk("R9", 1'b0, 3'd0);          // edge request was consumed
        req = 8'h08; settle();
        chk("R8", 1'b1, 3'd3);
        pulse_ack();
        pulse_eoi(3'd3);
        chk("R8", 1'b0, 3'd0);          // held high, no retrigger
        req = 8'h00; settle();
        req = 8'h08; settle();
        chk("R8", 1'b1, 3'd3);
        req = 8'h00;
        pulse_ack();
        pulse_eoi(3'd3);

        // Reset in the middle clears in-service state (R1).
        lvl = 8'hFF; req = 8'h10; settle();
        pulse_ack();
        chk("R4", 1'b0, 3'd0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1", 1'b0, 3'd0);
        @(negedge clk); rst_n = 1'b1;
        settle();
        chk("R1", 1'b1, 3'd4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule